// File: doc/BRIEF.md
# Dual-Edge Receive Delay Tuning Sequencer

This block searches for a working receive sampling point on a card interface. It has a delay line with a fixed number of taps and a choice of sampling on the rising or the falling clock edge. After one start pulse it runs two passes. The first pass tunes the command line and the second tunes the data lines. In each pass it sweeps every tap with rising-edge sampling and then every tap with falling-edge sampling. For each trial setting it asks an external agent for one tuning transfer and records whether that transfer passed. The result is one pass map per edge.

When a pass has swept both edges, two window evaluators scan the two maps in parallel. Each finds the best run of consecutive passing taps and derives one tap from it. The sequencer then picks an edge, drives the chosen setting onto the final outputs, and either moves on to the data pass or finishes. If the command pass finds no working setting, the data pass is skipped. The final outputs change only when an evaluation succeeds. At the end a one-cycle done pulse is given together with a status code.

Top module: `dtune_top`

## Requirements
- R1: Each pass issues NUM_DLY transfers with trial taps 0, 1, ..., NUM_DLY-1 on the rising edge (try_edge_o=0), then the same taps on the falling edge (try_edge_o=1). The command pass (try_path_o=0) comes before the data pass (try_path_o=1). The trial outputs hold steady while tune_req_o is high.
- R2: tune_req_o stays high until tune_ack_i is seen. tune_pass_i is sampled in the ack cycle, and a 1 marks that edge/tap as passing in its map.
- R3: If no ack arrives within ACK_TIMEOUT cycles of request, the request is withdrawn and the transfer counts as failing.
- R4: The evaluator finds the longest run of adjacent passing taps. Runs do not wrap past the last tap. Between runs of equal length the lower one wins. The scan stops early once a finished run is at least EARLY_LEN long while the best start so far is below EARLY_START.
- R5: The chosen tap is len/3 when the best run starts at tap 0. Otherwise it is start + len/2 (integer division).
- R6: The edge with the longer best run is chosen, and a tie selects rising (edge code 0 = rising, 1 = falling).
- R7: In the data pass the rising edge is chosen whenever its best run is at least DATA_PREF_LEN long, whatever the falling result.
- R8: If both command maps are empty, the data pass is not run and the status is 2'b01.
- R9: The data-pass edge drives both dat_rd_edge_o and dat_wr_edge_o. The status is 2'b10 when both data maps are empty and 2'b00 on full success.
- R10: cmd_edge_o/cmd_dly_o and dat_*_o change only when their own evaluation succeeds. They hold their value at all other times, including through a failed evaluation. All are 0 after reset.
- R11: done_o is a single-cycle pulse at the end of each run, with status_o valid in that cycle. busy_o is high from the start until that pulse.
- R12: start_i has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tuning run (one-cycle pulse) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| status_o | output | 2 | 00 ok, 01 command fail, 10 data fail |
| tune_req_o | output | 1 | Request one tuning transfer |
| tune_ack_i | input | 1 | Transfer finished |
| tune_pass_i | input | 1 | Transfer result, valid with ack |
| try_path_o | output | 1 | Line under trial: 0 command, 1 data |
| try_edge_o | output | 1 | Trial sampling edge: 0 rising, 1 falling |
| try_dly_o | output | $clog2(NUM_DLY) | Trial delay tap |
| cmd_edge_o | output | 1 | Final command sampling edge |
| cmd_dly_o | output | $clog2(NUM_DLY) | Final command delay tap |
| dat_rd_edge_o | output | 1 | Final read-data sampling edge |
| dat_wr_edge_o | output | 1 | Final write-data sampling edge |
| dat_dly_o | output | $clog2(NUM_DLY) | Final data delay tap |

## Verification
The bench builds the block with NUM_DLY=32, EARLY_LEN=8, EARLY_START=4 and DATA_PREF_LEN=10. At these values the early-stop rule, the divide-by-three rule for runs that start at tap 0, and the data-pass rising preference can all be reached with hand-written maps. ACK_TIMEOUT is cut to 12 so that muted transfers, which exercise the timeout path, cost little time. Random pass maps and sparse muted taps cover orderings of runs that the directed maps do not reach.

// File: rtl/dtune_pkg.sv
package dtune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_EWAIT
  } dtune_state_e;

  localparam logic [1:0] TS_OK       = 2'b00;
  localparam logic [1:0] TS_CMD_FAIL = 2'b01;
  localparam logic [1:0] TS_DAT_FAIL = 2'b10;

  localparam logic PATH_CMD = 1'b0;
  localparam logic PATH_DAT = 1'b1;

  localparam logic EDGE_RISE = 1'b0;
  localparam logic EDGE_FALL = 1'b1;
endpackage

// File: rtl/dtune_xfer.sv
module dtune_xfer #(
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic ack_i,
  input  logic pass_i,
  output logic req_o,
  output logic fin_o,
  output logic ok_o
);
  localparam int CW = (ACK_TIMEOUT > 1) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_TIMEOUT - 1);

  logic          req_q, fin_q, ok_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      fin_q <= 1'b0;
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        req_q <= 1'b1;
        cnt_q <= '0;
      end else if (req_q) begin
        if (ack_i) begin
          req_q <= 1'b0;
          fin_q <= 1'b1;
          ok_q  <= pass_i;
        end else if (cnt_q == CNT_LAST) begin
          // no answer: treat as a failing transfer
          req_q <= 1'b0;
          fin_q <= 1'b1;
          ok_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;
  assign fin_o = fin_q;
  assign ok_o  = ok_q;
endmodule

// File: rtl/dtune_eval.sv
module dtune_eval #(
  parameter int NUM_DLY     = 32,
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4,
  localparam int DW = $clog2(NUM_DLY),
  localparam int LW = $clog2(NUM_DLY + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [NUM_DLY-1:0] map_i,
  output logic               valid_o,
  output logic [LW-1:0]      len_o,
  output logic [DW-1:0]      phase_o
);
  localparam logic [DW-1:0] IDX_LAST = DW'(NUM_DLY - 1);

  logic          run_q, valid_q;
  logic [DW-1:0] idx_q, cur_start_q, best_start_q;
  logic [LW-1:0] cur_len_q, best_len_q;

  logic          bit_now, is_last, end_now, upd, stop;
  logic [LW-1:0] ext_len, end_len, nb_len;
  logic [DW-1:0] end_start, nb_start;

  always_comb begin
    bit_now = map_i[idx_q];
    is_last = (idx_q == IDX_LAST);
    ext_len = cur_len_q + 1'b1;
    if (bit_now) begin
      end_now   = is_last;
      end_len   = ext_len;
      end_start = (cur_len_q == '0) ? idx_q : cur_start_q;
    end else begin
      end_now   = (cur_len_q != '0);
      end_len   = cur_len_q;
      end_start = cur_start_q;
    end
    // strict compare keeps the earliest of equal runs
    upd      = end_now && (end_len > best_len_q);
    nb_len   = upd ? end_len : best_len_q;
    nb_start = upd ? end_start : best_start_q;
    stop     = is_last ||
               (end_now && (32'(end_len) >= EARLY_LEN) && (32'(nb_start) < EARLY_START));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      valid_q      <= 1'b0;
      idx_q        <= '0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (go_i) begin
      run_q        <= 1'b1;
      valid_q      <= 1'b0;
      idx_q        <= '0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (run_q) begin
      cur_len_q    <= bit_now ? ext_len : '0;
      cur_start_q  <= (bit_now && cur_len_q == '0) ? idx_q : cur_start_q;
      best_len_q   <= nb_len;
      best_start_q <= nb_start;
      idx_q        <= idx_q + 1'b1;
      if (stop) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  // start + len/2 never passes the last tap, so no wrap is needed
  logic [LW:0] phase_full;
  always_comb begin
    if (best_start_q == '0) phase_full = (LW+1)'(best_len_q / 3);
    else phase_full = (LW+1)'(best_start_q) + (LW+1)'(best_len_q >> 1);
  end

  assign valid_o = valid_q;
  assign len_o   = best_len_q;
  assign phase_o = phase_full[DW-1:0];
endmodule

// File: rtl/dtune_top.sv
module dtune_top
  import dtune_pkg::*;
#(
  parameter int NUM_DLY       = 32,
  parameter int ACK_TIMEOUT   = 1024,
  parameter int EARLY_LEN     = 8,
  parameter int EARLY_START   = 4,
  parameter int DATA_PREF_LEN = 10,
  localparam int DW = $clog2(NUM_DLY),
  localparam int LW = $clog2(NUM_DLY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    status_o,
  output logic          tune_req_o,
  input  logic          tune_ack_i,
  input  logic          tune_pass_i,
  output logic          try_path_o,
  output logic          try_edge_o,
  output logic [DW-1:0] try_dly_o,
  output logic          cmd_edge_o,
  output logic [DW-1:0] cmd_dly_o,
  output logic          dat_rd_edge_o,
  output logic          dat_wr_edge_o,
  output logic [DW-1:0] dat_dly_o
);
  localparam logic [DW-1:0] DLY_LAST = DW'(NUM_DLY - 1);

  dtune_state_e          state_q;
  logic                  path_q, edge_q;
  logic [DW-1:0]         dly_q;
  logic [1:0][NUM_DLY-1:0] map_q;
  logic                  done_q;
  logic [1:0]            status_q;
  logic                  cmd_edge_q, dat_edge_q;
  logic [DW-1:0]         cmd_dly_q, dat_dly_q;

  logic xfer_go, xfer_fin, xfer_ok, eval_go;
  assign xfer_go = (state_q == ST_ISSUE);
  assign eval_go = (state_q == ST_EVAL);

  dtune_xfer #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (xfer_go),
    .ack_i  (tune_ack_i),
    .pass_i (tune_pass_i),
    .req_o  (tune_req_o),
    .fin_o  (xfer_fin),
    .ok_o   (xfer_ok)
  );

  logic [1:0]          ev_valid;
  logic [1:0][LW-1:0]  ev_len;
  logic [1:0][DW-1:0]  ev_phase;

  for (genvar e = 0; e < 2; e++) begin : g_eval
    dtune_eval #(
      .NUM_DLY     (NUM_DLY),
      .EARLY_LEN   (EARLY_LEN),
      .EARLY_START (EARLY_START)
    ) u_eval (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (eval_go),
      .map_i   (map_q[e]),
      .valid_o (ev_valid[e]),
      .len_o   (ev_len[e]),
      .phase_o (ev_phase[e])
    );
  end

  logic          rise_wins, pick_fail;
  logic [DW-1:0] pick_phase;
  always_comb begin
    rise_wins = (ev_len[EDGE_RISE] >= ev_len[EDGE_FALL]) ||
                ((path_q == PATH_DAT) && (32'(ev_len[EDGE_RISE]) >= DATA_PREF_LEN));
    pick_fail  = rise_wins ? (ev_len[EDGE_RISE] == '0) : (ev_len[EDGE_FALL] == '0);
    pick_phase = rise_wins ? ev_phase[EDGE_RISE] : ev_phase[EDGE_FALL];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      path_q     <= PATH_CMD;
      edge_q     <= EDGE_RISE;
      dly_q      <= '0;
      map_q      <= '0;
      done_q     <= 1'b0;
      status_q   <= TS_OK;
      cmd_edge_q <= EDGE_RISE;
      cmd_dly_q  <= '0;
      dat_edge_q <= EDGE_RISE;
      dat_dly_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            path_q  <= PATH_CMD;
            edge_q  <= EDGE_RISE;
            dly_q   <= '0;
            map_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (xfer_fin) begin
            map_q[edge_q][dly_q] <= xfer_ok;
            if (dly_q == DLY_LAST) begin
              dly_q <= '0;
              if (edge_q == EDGE_FALL) begin
                state_q <= ST_EVAL;
              end else begin
                edge_q  <= EDGE_FALL;
                state_q <= ST_ISSUE;
              end
            end else begin
              dly_q   <= dly_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_EVAL: state_q <= ST_EWAIT;
        ST_EWAIT: begin
          if (&ev_valid) begin
            if (path_q == PATH_CMD) begin
              if (pick_fail) begin
                status_q <= TS_CMD_FAIL;
                done_q   <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                cmd_edge_q <= ~rise_wins;
                cmd_dly_q  <= pick_phase;
                path_q     <= PATH_DAT;
                edge_q     <= EDGE_RISE;
                map_q      <= '0;
                state_q    <= ST_ISSUE;
              end
            end else begin
              if (pick_fail) begin
                status_q <= TS_DAT_FAIL;
              end else begin
                status_q   <= TS_OK;
                dat_edge_q <= ~rise_wins;
                dat_dly_q  <= pick_phase;
              end
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign try_path_o    = path_q;
  assign try_edge_o    = edge_q;
  assign try_dly_o     = dly_q;
  assign cmd_edge_o    = cmd_edge_q;
  assign cmd_dly_o     = cmd_dly_q;
  assign dat_rd_edge_o = dat_edge_q;
  assign dat_wr_edge_o = dat_edge_q;
  assign dat_dly_o     = dat_dly_q;
endmodule

// File: rtl/dtune_top_chk.sv
module dtune_top_chk #(
  parameter int ACK_TIMEOUT = 1024,
  parameter int DW          = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          tune_req_o,
  input logic          tune_ack_i,
  input logic          try_path_o,
  input logic          try_edge_o,
  input logic [DW-1:0] try_dly_o,
  input logic          cmd_edge_o,
  input logic [DW-1:0] cmd_dly_o,
  input logic          dat_rd_edge_o,
  input logic [DW-1:0] dat_dly_o
);
  localparam int CW = $clog2(ACK_TIMEOUT + 1);
  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_cnt <= '0;
    else if (tune_req_o && !tune_ack_i) wait_cnt <= wait_cnt + 1'b1;
    else wait_cnt <= '0;
  end

  assert_trial_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_req_o && $past(tune_req_o) |-> $stable(try_dly_o) && $stable(try_edge_o) && $stable(try_path_o));

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_req_o && !tune_ack_i && (wait_cnt != CW'(ACK_TIMEOUT - 1)) |=> tune_req_o);

  assert_req_timeout_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_req_o && !tune_ack_i && (wait_cnt == CW'(ACK_TIMEOUT - 1)) |=> !tune_req_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(cmd_edge_o) && $stable(cmd_dly_o) && $stable(dat_rd_edge_o) && $stable(dat_dly_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind dtune_top dtune_top_chk #(
  .ACK_TIMEOUT (ACK_TIMEOUT),
  .DW          (DW)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .tune_req_o    (tune_req_o),
  .tune_ack_i    (tune_ack_i),
  .try_path_o    (try_path_o),
  .try_edge_o    (try_edge_o),
  .try_dly_o     (try_dly_o),
  .cmd_edge_o    (cmd_edge_o),
  .cmd_dly_o     (cmd_dly_o),
  .dat_rd_edge_o (dat_rd_edge_o),
  .dat_dly_o     (dat_dly_o)
);

// File: tb/dtune_top_tb.sv
module dtune_top_tb;
  localparam int N   = 32;
  localparam int DW  = 5;
  localparam int TMO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start, busy, done, req, ack, pass;
  logic [1:0]    status;
  logic          try_path, try_edge, cmd_edge, rd_edge, wr_edge;
  logic [DW-1:0] try_dly, cmd_dly, dat_dly;

  dtune_top #(
    .NUM_DLY(N), .ACK_TIMEOUT(TMO), .EARLY_LEN(8), .EARLY_START(4), .DATA_PREF_LEN(10)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .status_o(status), .tune_req_o(req), .tune_ack_i(ack), .tune_pass_i(pass),
    .try_path_o(try_path), .try_edge_o(try_edge), .try_dly_o(try_dly),
    .cmd_edge_o(cmd_edge), .cmd_dly_o(cmd_dly), .dat_rd_edge_o(rd_edge),
    .dat_wr_edge_o(wr_edge), .dat_dly_o(dat_dly)
  );

  int total = 0, bad = 0;
  logic [31:0] tbl  [0:1][0:1];
  logic [31:0] mute [0:1][0:1];
  int seq_idx, seq_bad, done_cnt;

  int e_cmd_edge = 0, e_cmd_dly = 0, e_dat_edge = 0, e_dat_dly = 0, e_status = 0, e_nreq = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // longest passing run, earliest on ties, with early stop
  function automatic void ref_best(input logic [31:0] m, output int len, output int ph);
    int pos = 0, bl = 0, bs = 0;
    while (pos < N) begin
      int l = 0;
      while (pos + l < N && m[pos+l]) l++;
      if (bl < l) begin bs = pos; bl = l; end
      pos += (l != 0) ? l : 1;
      if (l >= 8 && bs < 4) break;
    end
    len = bl;
    ph  = (bs == 0) ? bl / 3 : bs + bl / 2;
  endfunction

  function automatic void ref_pick(input logic [31:0] rm, input logic [31:0] fm, input bit dat,
                                   output bit fail, output int edge_sel, output int dly);
    int rl, rp, fl, fp;
    bit rw;
    ref_best(rm, rl, rp);
    ref_best(fm, fl, fp);
    rw = (rl >= fl) || (dat && rl >= 10);
    edge_sel = rw ? 0 : 1;
    dly  = rw ? rp : fp;
    fail = rw ? (rl == 0) : (fl == 0);
  endfunction

  // tuning-transfer agent
  initial begin
    bit seen = 0;
    ack = 0; pass = 0;
    forever begin
      @(negedge clk);
      if (req && !seen) begin
        int p, e, d;
        seen = 1;
        p = seq_idx / 64; e = (seq_idx / 32) % 2; d = seq_idx % 32;
        if (int'(try_path) != p || int'(try_edge) != e || int'(try_dly) != d) seq_bad++;
        seq_idx++;
        if (!mute[try_path][try_edge][try_dly]) begin
          logic v;
          v = tbl[try_path][try_edge][try_dly];
          repeat ($urandom % 4) @(negedge clk);
          ack = 1; pass = v;
          @(negedge clk);
          ack = 0; pass = 0;
        end
      end else if (!req) begin
        seen = 0;
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic run_case(input string name);
    bit cf, df;
    int ce, cd, de, dd;
    int o_ce, o_cd, o_de, o_dd;
    o_ce = e_cmd_edge; o_cd = e_cmd_dly; o_de = e_dat_edge; o_dd = e_dat_dly;
    ref_pick(tbl[0][0] & ~mute[0][0], tbl[0][1] & ~mute[0][1], 0, cf, ce, cd);
    if (cf) begin
      e_status = 1; e_nreq = 64;
    end else begin
      e_cmd_edge = ce; e_cmd_dly = cd; e_nreq = 128;
      ref_pick(tbl[1][0] & ~mute[1][0], tbl[1][1] & ~mute[1][1], 1, df, de, dd);
      if (df) e_status = 2;
      else begin e_status = 0; e_dat_edge = de; e_dat_dly = dd; end
    end
    seq_idx = 0; seq_bad = 0; done_cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    check(busy == 1, {"R11 busy during run ", name}, busy, 1);
    check(cmd_dly == o_cd && cmd_edge == o_ce && dat_dly == o_dd && rd_edge == o_de,
          {"R10 held mid-run ", name}, cmd_dly, o_cd);
    start = 1;  // R12: ignored while busy
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    check(busy == 0, {"R11 busy low at done ", name}, busy, 0);
    check(int'(status) == e_status, {"R8 R9 status ", name}, status, e_status);
    check(int'(cmd_edge) == e_cmd_edge, {"R6 cmd edge ", name}, cmd_edge, e_cmd_edge);
    check(int'(cmd_dly) == e_cmd_dly, {"R4 R5 cmd tap ", name}, cmd_dly, e_cmd_dly);
    check(int'(rd_edge) == e_dat_edge && int'(wr_edge) == e_dat_edge,
          {"R7 R9 data edges ", name}, {rd_edge, wr_edge}, e_dat_edge);
    check(int'(dat_dly) == e_dat_dly, {"R5 R10 data tap ", name}, dat_dly, e_dat_dly);
    repeat (4) @(negedge clk);
    check(done_cnt == 1 && busy == 0, {"R11 R12 single done ", name}, done_cnt, 1);
    check(seq_bad == 0, {"R1 sweep order ", name}, seq_bad, 0);
    check(seq_idx == e_nreq, {"R1 R8 request count ", name}, seq_idx, e_nreq);
  endtask

  task automatic clear_tbl();
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 2; e++) begin tbl[p][e] = '0; mute[p][e] = '0; end
  endtask

  function automatic logic [31:0] span(input int lo, input int hi);
    logic [31:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    start = 0;
    clear_tbl();
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && req == 0 && status == 0, "R10 R11 reset idle", busy, 0);
    check(cmd_dly == 0 && dat_dly == 0 && cmd_edge == 0 && rd_edge == 0 && wr_edge == 0,
          "R10 reset outputs", cmd_dly, 0);

    // R4 early stop: rising 0..7 stops before 10..25; falling 16 long wins
    clear_tbl();
    tbl[0][0] = span(0, 7) | span(10, 25); tbl[0][1] = span(12, 27);
    tbl[1][0] = 32'hFFFF_FFFF;
    run_case("early-stop");

    // R8 command maps empty
    clear_tbl();
    tbl[1][0] = 32'hFFFF_FFFF; tbl[1][1] = 32'hFFFF_FFFF;
    run_case("cmd-fail");

    // R7 data rising preferred at len 10; command picks longer falling
    clear_tbl();
    tbl[0][0] = span(3, 12); tbl[0][1] = span(0, 19);
    tbl[1][0] = span(3, 12); tbl[1][1] = span(0, 19);
    run_case("data-pref");

    // R6 tie goes rising
    clear_tbl();
    tbl[0][0] = span(5, 14); tbl[0][1] = span(16, 25);
    tbl[1][0] = span(4, 12); tbl[1][1] = span(20, 28);
    run_case("tie");

    // R9 data maps empty
    clear_tbl();
    tbl[0][0] = span(20, 31);
    run_case("data-fail");

    // R3 muted taps time out and count as failing
    clear_tbl();
    tbl[0][0] = 32'hFFFF_FFFF; mute[0][0] = 32'h0001_0000;
    tbl[0][1] = span(1, 31);   mute[0][1] = 32'h0000_0040;
    tbl[1][0] = span(2, 9);    tbl[1][1] = span(6, 30); mute[1][1] = 32'h0000_2000;
    run_case("timeout");

    for (int k = 0; k < 6; k++) begin
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 2; e++) begin
          tbl[p][e]  = (k % 2 == 0) ? ($urandom | $urandom) : ($urandom & $urandom | $urandom);
          mute[p][e] = $urandom & $urandom & $urandom & $urandom;
        end
      run_case($sformatf("random-%0d", k));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule